// File: doc/BRIEF.md
# Paged I/O Address Translation Unit

This block turns addresses issued by a DMA-capable device into physical page addresses. It holds one 64-bit entry per I/O page in a register array. A lookup subtracts the window base supplied with the request from the I/O address, then shifts the result right by the programmed page shift to form a table index. The entry's upper bits give the physical page and its two lowest bits give the access rights. The registered response carries the page-aligned window offset, the translated page address, an offset mask and a 2-bit permission.

Software-side control is a two-state machine. In `ST_OFF` the table has no pages, so every lookup misses. The `EV_ENABLE` transition (`ST_OFF` to `ST_ON`) takes a page shift and an entry count. The `EV_DISABLE` transition (`ST_ON` to `ST_OFF`) zeroes the count, the shift and every entry. Any request that does not match one of these transitions leaves the state as it is. Entries are written one at a time through an index/data port. A clear strobe wipes every entry at once.

Top module: `pgx_iommu`

## Requirements
- R1: The two lowest bits of an entry set the response permission: 0 no access, 1 read only, 2 write only, 3 read and write.
- R2: The index is (address - base) shifted right by the page shift. A lookup hits only when address >= base and the index is below the enabled entry count.
- R3: On a hit, `rsp_iova` is (address - base) with the low page-shift bits cleared. `rsp_pa` is the entry with the same bits cleared.
- R4: On a hit, `rsp_mask` equals 2^shift - 1.
- R5: On a miss, `rsp_perm` is 0, `rsp_iova` and `rsp_pa` are 0, and `rsp_mask` is all ones.
- R6: An `EV_ENABLE` shift field of 0 selects a shift of 12. An enable is ignored when the resulting shift is outside 12..24 or the count is outside 1..ENTRIES.
- R7: A `tbl_clr` strobe sets every entry to zero, so every page becomes no-access.
- R8: In `ST_OFF` the count and shift are zero and every lookup misses. `EV_DISABLE` zeroes every entry.
- R9: An enable request while in `ST_ON` is ignored.
- R10: `rsp_valid` rises exactly one cycle after each `req_valid` cycle. Back-to-back requests give back-to-back responses.
- R11: A table write issued in `ST_OFF`, or with an index at or above the enabled count, is ignored.
- R12: After reset the unit is in `ST_OFF` and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Enable strobe (`EV_ENABLE`) |
| cfg_dis | input | 1 | Disable strobe (`EV_DISABLE`); wins over `cfg_en` |
| cfg_shift | input | 5 | Page shift for enable; 0 selects 12 |
| cfg_count | input | CNT_W | Number of entries for enable |
| tbl_clr | input | 1 | Zero all entries |
| tbl_wr | input | 1 | Write one entry |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_data | input | ADDR_W | Entry value: page address, permission in bits 1:0 |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | I/O address |
| req_base | input | ADDR_W | Window base for this request |
| rsp_valid | output | 1 | Response valid |
| rsp_iova | output | ADDR_W | Page-aligned window offset |
| rsp_pa | output | ADDR_W | Translated page address |
| rsp_mask | output | ADDR_W | Offset mask |
| rsp_perm | output | 2 | Permission code |

## Verification
Lookups use entries holding each of the four permission codes, to separate the permission decode from the address masking. Addresses sit just below the base, at the last valid index and at the first invalid index, to catch off-by-one errors in the bounds compare. Three configurations (default shift, shift 24 with the full 512 entries, and rejected shift or count values) show whether the mask follows the programmed shift and whether invalid enables are refused. Re-enable, write-while-off, clear and disable sequences are followed by lookups, so every ignored or wiping action can be seen through the response port.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } cfg_state_e;

    localparam int unsigned SHIFT_W    = 5;
    localparam int unsigned SHIFT_MIN  = 12;
    localparam int unsigned SHIFT_MAX  = 24;
    localparam int unsigned SHIFT_DFLT = 12;
endpackage

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
#(
    parameter int unsigned ENTRIES = 512,
    parameter int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_dis,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [CNT_W-1:0]   cfg_count,
    output logic               st_on,
    output logic               wipe,
    output logic [SHIFT_W-1:0] cur_shift,
    output logic [CNT_W-1:0]   cur_count
);
    cfg_state_e state, state_nx;
    logic [SHIFT_W-1:0] eff_shift;
    logic params_ok;
    logic ev_enable, ev_disable;

    assign eff_shift = (cfg_shift == '0) ? SHIFT_W'(SHIFT_DFLT) : cfg_shift;
    assign params_ok = (eff_shift >= SHIFT_W'(SHIFT_MIN)) && (eff_shift <= SHIFT_W'(SHIFT_MAX))
                    && (cfg_count != '0) && (cfg_count <= CNT_W'(ENTRIES));
    assign ev_enable  = (state == ST_OFF) && cfg_en && params_ok;
    assign ev_disable = (state == ST_ON) && cfg_dis;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (ev_enable)  state_nx = ST_ON;
            ST_ON:  if (ev_disable) state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_shift <= '0;
            cur_count <= '0;
        end else if (ev_enable) begin
            cur_shift <= eff_shift;
            cur_count <= cfg_count;
        end else if (ev_disable) begin
            cur_shift <= '0;
            cur_count <= '0;
        end
    end

    assign st_on = (state == ST_ON);
    assign wipe  = ev_disable;

    AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (cur_count == '0 && cur_shift == '0)); // R8
    AST_SHIFT_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON) |-> (cur_shift >= SHIFT_W'(SHIFT_MIN) && cur_shift <= SHIFT_W'(SHIFT_MAX))); // R6
    AST_REENABLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && cfg_en && !cfg_dis) |=> ($stable(cur_shift) && $stable(cur_count))); // R9
endmodule

// File: rtl/pgx_table.sv
module pgx_table #(
    parameter int unsigned ENTRIES = 512,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                      mem[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))  mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem[0] == '0)); // R7
endmodule

// File: rtl/pgx_lookup.sv
module pgx_lookup
    import pgx_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned CNT_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [SHIFT_W-1:0] cur_shift,
    input  logic [CNT_W-1:0]   cur_count,
    input  logic [ADDR_W-1:0]  rd_data,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_iova,
    output logic [ADDR_W-1:0]  rsp_pa,
    output logic [ADDR_W-1:0]  rsp_mask,
    output perm_e              rsp_perm
);
    logic [ADDR_W-1:0] offset, idx_full, page_mask;
    logic hit;

    assign offset    = req_addr - req_base;
    assign idx_full  = offset >> cur_shift;
    assign hit       = (req_addr >= req_base) && (idx_full < ADDR_W'(cur_count));
    assign page_mask = ~((ADDR_W'(1) << cur_shift) - ADDR_W'(1));
    assign rd_idx    = idx_full[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_iova  <= '0;
            rsp_pa    <= '0;
            rsp_mask  <= '1;
            rsp_perm  <= PERM_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (hit) begin
                    rsp_iova <= offset & page_mask;
                    rsp_pa   <= rd_data & page_mask;
                    rsp_mask <= ~page_mask;
                    rsp_perm <= perm_e'(rd_data[1:0]);
                end else begin
                    rsp_iova <= '0;
                    rsp_pa   <= '0;
                    rsp_mask <= '1;
                    rsp_perm <= PERM_NONE;
                end
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_MISS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_mask == '1) |-> (rsp_pa == '0 && rsp_iova == '0 && rsp_perm == PERM_NONE)); // R5
    AST_PA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_pa & rsp_mask) == '0 && (rsp_iova & rsp_mask) == '0)); // R3
endmodule

// File: rtl/pgx_iommu.sv
module pgx_iommu
    import pgx_pkg::*;
#(
    parameter  int unsigned ENTRIES = 512,
    parameter  int unsigned ADDR_W  = 64,
    localparam int unsigned IDX_W   = $clog2(ENTRIES),
    localparam int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_dis,
    input  logic [4:0]        cfg_shift,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              tbl_clr,
    input  logic              tbl_wr,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_base,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_iova,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic [ADDR_W-1:0] rsp_mask,
    output logic [1:0]        rsp_perm
);
    logic               st_on, wipe, wr_ok;
    logic [SHIFT_W-1:0] cur_shift;
    logic [CNT_W-1:0]   cur_count;
    logic [IDX_W-1:0]   rd_idx;
    logic [ADDR_W-1:0]  rd_data;
    perm_e              perm_q;

    pgx_ctrl #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dis(cfg_dis),
        .cfg_shift(cfg_shift), .cfg_count(cfg_count), .st_on(st_on), .wipe(wipe),
        .cur_shift(cur_shift), .cur_count(cur_count)
    );

    assign wr_ok = tbl_wr && st_on && (CNT_W'(tbl_idx) < cur_count);

    pgx_table #(.ENTRIES(ENTRIES), .DATA_W(ADDR_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr || wipe), .wr_en(wr_ok),
        .wr_idx(tbl_idx), .wr_data(tbl_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    pgx_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_base(req_base), .cur_shift(cur_shift), .cur_count(cur_count),
        .rd_data(rd_data), .rd_idx(rd_idx), .rsp_valid(rsp_valid),
        .rsp_iova(rsp_iova), .rsp_pa(rsp_pa), .rsp_mask(rsp_mask), .rsp_perm(perm_q)
    );

    assign rsp_perm = perm_q;
endmodule

// File: tb/pgx_iommu_tb.sv
module pgx_iommu_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ENTRIES    = 512;
    localparam int unsigned CNT_W      = $clog2(ENTRIES + 1);
    localparam int unsigned IDX_W      = $clog2(ENTRIES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_dis = 1'b0, tbl_clr = 1'b0, tbl_wr = 1'b0, req_valid = 1'b0;
    logic [4:0] cfg_shift = '0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic [63:0] tbl_data = '0, req_addr = '0, req_base = '0;
    logic rsp_valid;
    logic [63:0] rsp_iova, rsp_pa, rsp_mask;
    logic [1:0] rsp_perm;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [63:0] iova;
        logic [63:0] pa;
        logic [63:0] mask;
        logic [1:0]  perm;
        string       tag;
    } exp_t;
    exp_t expq[$];

    logic        m_on = 1'b0;
    int unsigned m_shift = 0;
    int unsigned m_count = 0;
    logic [63:0] m_tab [ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgx_iommu u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dis(cfg_dis),
        .cfg_shift(cfg_shift), .cfg_count(cfg_count), .tbl_clr(tbl_clr),
        .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_base(req_base),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_pa(rsp_pa),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
    );

    // monitor: compares every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10: response with nothing expected (actual valid=1, expected valid=0)");
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (rsp_iova !== e.iova || rsp_pa !== e.pa || rsp_mask !== e.mask || rsp_perm !== e.perm) begin
                    errors++;
                    $display("FAIL %s: actual iova=%h pa=%h mask=%h perm=%0d expected iova=%h pa=%h mask=%h perm=%0d",
                             e.tag, rsp_iova, rsp_pa, rsp_mask, rsp_perm, e.iova, e.pa, e.mask, e.perm);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        cfg_en = 0; cfg_dis = 0; tbl_clr = 0; tbl_wr = 0; req_valid = 0;
    endtask

    task automatic do_enable(input int unsigned sh, input int unsigned cnt);
        int unsigned eff;
        idle();
        cfg_en = 1; cfg_shift = 5'(sh); cfg_count = CNT_W'(cnt);
        eff = (sh == 0) ? 12 : sh;
        if (!m_on && eff >= 12 && eff <= 24 && cnt >= 1 && cnt <= ENTRIES) begin
            m_on = 1; m_shift = eff; m_count = cnt;
        end
    endtask

    task automatic do_disable();
        idle();
        cfg_dis = 1;
        if (m_on) begin
            m_on = 0; m_shift = 0; m_count = 0;
            for (int i = 0; i < ENTRIES; i++) m_tab[i] = '0;
        end
    endtask

    task automatic do_clear();
        idle();
        tbl_clr = 1;
        for (int i = 0; i < ENTRIES; i++) m_tab[i] = '0;
    endtask

    task automatic do_write(input int unsigned idx, input logic [63:0] d);
        idle();
        tbl_wr = 1; tbl_idx = IDX_W'(idx); tbl_data = d;
        if (m_on && idx < m_count) m_tab[idx] = d;
    endtask

    task automatic lookup(input logic [63:0] a, input logic [63:0] b, input string tag);
        exp_t e;
        logic [63:0] off, pm;
        idle();
        req_valid = 1; req_addr = a; req_base = b;
        off = a - b;
        pm = ~((64'd1 << m_shift) - 64'd1);
        e.tag = tag;
        if (m_on && a >= b && (off >> m_shift) < 64'(m_count)) begin
            e.iova = off & pm;
            e.pa   = m_tab[off >> m_shift] & pm;
            e.mask = ~pm;
            e.perm = m_tab[off >> m_shift][1:0];
        end else begin
            e.iova = '0; e.pa = '0; e.mask = '1; e.perm = 2'd0;
        end
        expq.push_back(e);
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) m_tab[i] = '0;
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual run still busy, expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R12: rsp_valid actual %b expected 0", rsp_valid);
        end
        lookup(64'h1000, 64'h0, "R8 off-miss");
        lookup(64'h0, 64'h0, "R12 off-miss");

        // shift field 0 selects 12, eight entries
        do_enable(0, 8);
        do_write(0, 64'h0000_0000_7770_0000);
        do_write(1, 64'h0000_0000_1234_5001);
        do_write(2, 64'h0000_00AB_CDEF_0FF2);
        do_write(3, 64'hFFFF_0000_0000_1003);
        // back-to-back lookups, perm codes 0..3
        lookup(64'h1_0123, 64'h1_0000, "R1 perm-none");
        lookup(64'h1_1456, 64'h1_0000, "R1 perm-rd");
        lookup(64'h1_2FFF, 64'h1_0000, "R3 perm-wr");
        lookup(64'h1_3000, 64'h1_0000, "R4 perm-rw");
        lookup(64'h0_FFFF, 64'h1_0000, "R2 below-base");
        lookup(64'h1_7ABC, 64'h1_0000, "R2 last-index");
        lookup(64'h1_8000, 64'h1_0000, "R5 first-past-end");

        // re-enable while on must not change shift or count
        do_enable(16, 4);
        do_write(5, 64'h0000_0000_ABCD_E003);
        lookup(64'h5010, 64'h0, "R9 reenable-ignored");
        lookup(64'h7010, 64'h0, "R9 count-kept");

        do_clear();
        lookup(64'h1010, 64'h0, "R7 cleared");
        lookup(64'h5010, 64'h0, "R7 cleared-rw");

        do_write(2, 64'h0000_0000_0055_5003);
        do_disable();
        lookup(64'h2000, 64'h0, "R8 disabled-miss");
        do_write(2, 64'h0000_0000_0066_6003);
        do_enable(24, 512);
        lookup(64'h0000_0000_0212_3456, 64'h0, "R11 write-while-off");
        do_write(511, 64'h0000_0003_0F00_0001);
        lookup(64'h0000_0001_FFAB_CDEF, 64'h0, "R4 shift24-last");
        lookup(64'h0000_0002_0000_0000, 64'h0, "R2 shift24-end");

        do_disable();
        do_enable(25, 4);
        lookup(64'h10, 64'h0, "R6 shift-too-big");
        do_enable(11, 4);
        lookup(64'h10, 64'h0, "R6 shift-too-small");
        do_enable(12, 0);
        lookup(64'h10, 64'h0, "R6 count-zero");
        do_enable(12, 513);
        lookup(64'h10, 64'h0, "R6 count-too-big");
        do_enable(13, 4);
        do_write(3, 64'h0000_0000_0009_E002);
        lookup(64'h7FFF, 64'h0, "R6 shift13-hit");

        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R10: responses outstanding actual %0d expected 0", expq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule